// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox placed between a host processor's load/store bus and an on-chip firmware controller. The host issues a command by first filling a small outbound data area with 32-bit words and then writing a single command word. That write is accepted only while the mailbox is idle. An accepted write latches the command fields, marks the mailbox busy and sends a one-cycle doorbell to the controller.

The controller reads the latched command fields and the outbound words through its own port, and it places any response words in an inbound data area. It finishes the exchange with a completion strobe that carries a failure flag, an error code and an initiator tag. Completion clears busy. If the accepted command asked for it, completion also sends the host a single-cycle interrupt pulse. Without that request, the host polls the status word until busy drops and then checks the failure flag.

Top module: `ipc_mailbox`

## Requirements
- R1: After synchronous reset, the status word reads 0 (idle, no error), and both the doorbell and the host interrupt are low.
- R2: A host write to offset 0x00 while idle is accepted. The cycle after the write edge, busy reads 1 and the doorbell is high for exactly that one cycle. The controller then sees the opcode from bits [7:0], the interrupt request from bit 8, the command id from bits [15:12] and the size from bits [23:16]. Accepting a command clears the error flag and the error code.
- R3: Busy stays set, however many cycles pass, until the controller's completion strobe. That strobe clears busy and loads the error flag, the error code and the initiator tag.
- R4: A write to offset 0x00 while busy is ignored: it raises no doorbell and leaves the command fields seen by the controller unchanged.
- R5: The status word at offset 0x04 places busy at bit 0, the error flag at bit 1, the command id of the last accepted command at [7:4], the initiator tag at [15:8] and the error code at [23:16]. All other bits read 0.
- R6: The host interrupt is a one-cycle pulse in the cycle after the completion strobe. It occurs only if the accepted command had bit 8 set.
- R7: A completion strobe while idle has no effect: the status word is unchanged and no interrupt is raised.
- R8: A host word write to 0x80+4k (k = 0..3) stores word k of the outbound area, which the controller reads by index k. Such writes are ignored while busy.
- R9: A controller write of index k stores word k of the inbound area, and the host reads it in word mode at 0x90+4k.
- R10: In byte mode, a host read of 0x90+n (n = 0..15) returns byte n of the inbound area (little-endian within each word) in bits [7:0], with the upper bits 0.
- R11: Write-only and unmapped locations (0x00, 0x80..0x8F, others) read as 0. Host writes to 0x04 or to 0x90..0x9F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rd_byte | input | 1 | Host read mode: 1 = byte, 0 = word |
| host_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt pulse to the host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctl_opcode | output | 8 | Latched command opcode |
| ctl_ioc | output | 1 | Latched interrupt-on-completion request |
| ctl_cmd_id | output | 4 | Latched command id |
| ctl_size | output | 8 | Latched payload size |
| ctl_wbuf_idx | input | 2 | Outbound word index for the controller |
| ctl_wbuf_data | output | 32 | Outbound word at that index |
| ctl_rbuf_we | input | 1 | Controller inbound-word write strobe |
| ctl_rbuf_idx | input | 2 | Inbound word index |
| ctl_rbuf_data | input | 32 | Inbound word data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Failure flag, captured on completion |
| ctl_err_code | input | 8 | Error code, captured on completion |
| ctl_initiator | input | 8 | Initiator tag, captured on completion |

## Verification
The command path is driven three ways:
- An idle write with the interrupt bit set.
- A write made while busy.
- An idle write with the interrupt bit clear.

Comparing the first two separates acceptance from rejection, through the doorbell and the latched fields. Comparing the first and third shows that the interrupt follows bit 8 alone and that a new command clears the old error. Completion strobes that fail, succeed and arrive while idle show which status fields are captured and which are held. The inbound area is read in word and byte mode at every byte lane, and writes are aimed at read-only and busy-locked locations to confirm that each is refused.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int OFF_CMD  = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_WBUF = 'h80;
    localparam int OFF_RBUF = 'h90;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] size;
        logic [3:0] cmd_id;
        logic [2:0] rsv_lo;
        logic       ioc;
        logic [7:0] opcode;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] err_code;
        logic [7:0] initiator;
        logic [3:0] cmd_id;
        logic [1:0] rsv_lo;
        logic       err;
        logic       busy;
    } stat_word_t;

    function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] sel);
        return w[sel*8 +: 8];
    endfunction

endpackage

// File: rtl/mbox_cmd_ctrl.sv
module mbox_cmd_ctrl
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [31:0] wr_data,
    input  logic       ctl_done,
    input  logic       ctl_err,
    input  logic [7:0] ctl_err_code,
    input  logic [7:0] ctl_initiator,
    output logic       busy,
    output logic       doorbell,
    output logic       irq,
    output cmd_word_t  cmd_q,
    output stat_word_t stat
);
    logic       busy_q, bell_q, irq_q, err_q;
    logic [7:0] code_q, init_q;
    logic       accept, finish;

    assign accept = cmd_wr && !busy_q;
    assign finish = ctl_done && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            bell_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
            code_q <= '0;
            init_q <= '0;
            cmd_q  <= '0;
        end else begin
            bell_q <= accept;
            irq_q  <= finish && cmd_q.ioc;
            if (accept) begin
                busy_q <= 1'b1;
                cmd_q  <= cmd_word_t'(wr_data);
                err_q  <= 1'b0;
                code_q <= '0;
            end else if (finish) begin
                busy_q <= 1'b0;
                err_q  <= ctl_err;
                code_q <= ctl_err_code;
                init_q <= ctl_initiator;
            end
        end
    end

    always_comb begin
        stat           = '0;
        stat.busy      = busy_q;
        stat.err       = err_q;
        stat.cmd_id    = cmd_q.cmd_id;
        stat.initiator = init_q;
        stat.err_code  = code_q;
    end

    assign busy     = busy_q;
    assign doorbell = bell_q;
    assign irq      = irq_q;

    // R2: an idle command write raises busy and the doorbell
    assert_accept_rings_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy_q) |=> (busy_q && bell_q));

    // R4: a doorbell only marks the first busy cycle
    assert_no_second_bell_R4: assert property (@(posedge clk) disable iff (rst)
        bell_q |-> (busy_q && !$past(busy_q)));

    // R3: busy holds until a completion strobe
    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ctl_done) |=> busy_q);

    // R6: interrupt is a single pulse that follows the end of busy
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);
    assert_irq_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(busy_q) && !busy_q));

    // R7: a strobe while idle leaves the error state alone
    assert_idle_done_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && ctl_done && !cmd_wr) |=> ($stable(err_q) && $stable(code_q)));
endmodule

// File: rtl/mbox_wbuf.sv
module mbox_wbuf #(
    parameter int WORDS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && widx == IDX_W'(g))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/mbox_rbuf.sv
module mbox_rbuf
    import mbox_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    input  logic [1:0]       lane,
    output logic [31:0]      rword,
    output logic [7:0]       rbyte
);
    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && widx == IDX_W'(g))
                mem[g] <= wdata;
        end
    end

    assign rword = mem[ridx];
    assign rbyte = lane_of(mem[ridx], lane);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic        host_rd_byte,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    output logic        ctl_doorbell,
    output logic [7:0]  ctl_opcode,
    output logic        ctl_ioc,
    output logic [3:0]  ctl_cmd_id,
    output logic [7:0]  ctl_size,
    input  logic [1:0]  ctl_wbuf_idx,
    output logic [31:0] ctl_wbuf_data,
    input  logic        ctl_rbuf_we,
    input  logic [1:0]  ctl_rbuf_idx,
    input  logic [31:0] ctl_rbuf_data,
    input  logic        ctl_done,
    input  logic        ctl_err,
    input  logic [7:0]  ctl_err_code,
    input  logic [7:0]  ctl_initiator
);
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int BUF_BYTES = BUF_WORDS * 4;

    logic       busy;
    cmd_word_t  cmd_q;
    stat_word_t stat;
    logic       hit_cmd, hit_stat, hit_wbuf, hit_rbuf, wbuf_we;
    logic [IDX_W-1:0] host_idx;
    logic [31:0] rb_word;
    logic [7:0]  rb_byte;

    assign hit_cmd  = (host_addr == ADDR_W'(OFF_CMD));
    assign hit_stat = (host_addr == ADDR_W'(OFF_STAT));
    assign hit_wbuf = (host_addr >= ADDR_W'(OFF_WBUF)) && (host_addr < ADDR_W'(OFF_WBUF + BUF_BYTES));
    assign hit_rbuf = (host_addr >= ADDR_W'(OFF_RBUF)) && (host_addr < ADDR_W'(OFF_RBUF + BUF_BYTES));
    assign host_idx = host_addr[IDX_W+1:2];
    assign wbuf_we  = host_wr && hit_wbuf && (host_addr[1:0] == 2'b00) && !busy;

    mbox_cmd_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_wr(host_wr && hit_cmd), .wr_data(host_wdata),
        .ctl_done(ctl_done), .ctl_err(ctl_err),
        .ctl_err_code(ctl_err_code), .ctl_initiator(ctl_initiator),
        .busy(busy), .doorbell(ctl_doorbell), .irq(host_irq),
        .cmd_q(cmd_q), .stat(stat)
    );

    mbox_wbuf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_wbuf (
        .clk(clk), .rst(rst),
        .we(wbuf_we), .widx(host_idx), .wdata(host_wdata),
        .ridx(ctl_wbuf_idx), .rdata(ctl_wbuf_data)
    );

    mbox_rbuf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_rbuf (
        .clk(clk), .rst(rst),
        .we(ctl_rbuf_we), .widx(ctl_rbuf_idx), .wdata(ctl_rbuf_data),
        .ridx(host_idx), .lane(host_addr[1:0]),
        .rword(rb_word), .rbyte(rb_byte)
    );

    always_comb begin
        host_rdata = '0;
        if (hit_stat)
            host_rdata = stat;
        else if (hit_rbuf)
            host_rdata = host_rd_byte ? {24'h0, rb_byte} : rb_word;
    end

    assign ctl_opcode = cmd_q.opcode;
    assign ctl_ioc    = cmd_q.ioc;
    assign ctl_cmd_id = cmd_q.cmd_id;
    assign ctl_size   = cmd_q.size;

    // R8: outbound words are frozen while a command is in flight
    assert_wbuf_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ctl_wbuf_data) || $changed(ctl_wbuf_idx));
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
    logic        clk = 0;
    logic        rst = 1;
    logic        host_wr = 0;
    logic [7:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic        host_rd_byte = 0;
    logic [31:0] host_rdata;
    logic        host_irq, ctl_doorbell, ctl_ioc;
    logic [7:0]  ctl_opcode, ctl_size;
    logic [3:0]  ctl_cmd_id;
    logic [1:0]  ctl_wbuf_idx = 0;
    logic [31:0] ctl_wbuf_data;
    logic        ctl_rbuf_we = 0;
    logic [1:0]  ctl_rbuf_idx = 0;
    logic [31:0] ctl_rbuf_data = 0;
    logic        ctl_done = 0, ctl_err = 0;
    logic [7:0]  ctl_err_code = 0, ctl_initiator = 0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ipc_mailbox u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, input logic bmode, output logic [31:0] d);
        host_addr = a; host_rd_byte = bmode;
        #1 d = host_rdata;
        host_rd_byte = 0;
    endtask

    task automatic cwrite(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
        @(negedge clk);
        ctl_rbuf_we = 0;
    endtask

    task automatic complete(input logic e, input logic [7:0] c, input logic [7:0] t);
        @(negedge clk);
        ctl_done = 1; ctl_err = e; ctl_err_code = c; ctl_initiator = t;
        @(negedge clk);
        ctl_done = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        hread(8'h04, 0, d); check("R1 status", d, 0);
        check("R1 doorbell", {31'h0, ctl_doorbell}, 0);
        check("R1 irq", {31'h0, host_irq}, 0);
    endtask

    task automatic t_wbuf();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) hwrite(8'h80 + 8'(4*k), 32'hA0B0C000 + k);
        for (int k = 0; k < 4; k++) begin
            ctl_wbuf_idx = 2'(k); #1;
            check("R8 outbound word", ctl_wbuf_data, 32'hA0B0C000 + k);
        end
        hread(8'h80, 0, d); check("R11 outbound reads 0", d, 0);
        hread(8'h00, 0, d); check("R11 command reads 0", d, 0);
    endtask

    task automatic t_cmd_ioc();
        logic [31:0] d;
        hwrite(8'h00, 32'h0008_51FF);
        check("R2 doorbell", {31'h0, ctl_doorbell}, 1);
        check("R2 fields", {ctl_size, ctl_cmd_id, 3'b0, ctl_ioc, ctl_opcode}, 24'h0851FF);
        hread(8'h04, 0, d); check("R5 busy status", d, 32'h0000_0051);
        @(negedge clk);
        check("R2 doorbell one cycle", {31'h0, ctl_doorbell}, 0);
        hwrite(8'h00, 32'h0000_7033);
        check("R4 no second doorbell", {31'h0, ctl_doorbell}, 0);
        check("R4 fields kept", {ctl_size, ctl_cmd_id, 3'b0, ctl_ioc, ctl_opcode}, 24'h0851FF);
        hwrite(8'h80, 32'hDEADBEEF);
        ctl_wbuf_idx = 0; #1;
        check("R8 locked while busy", ctl_wbuf_data, 32'hA0B0C000);
        repeat (20) @(negedge clk);
        hread(8'h04, 0, d); check("R3 still busy", d, 32'h0000_0051);
        cwrite(0, 32'h4433_2211); cwrite(1, 32'h8877_6655);
        cwrite(2, 32'hCCBB_AA99); cwrite(3, 32'h00FF_EEDD);
        complete(1, 8'h2A, 8'h03);
        check("R6 irq pulse", {31'h0, host_irq}, 1);
        hread(8'h04, 0, d); check("R3 R5 completion status", d, 32'h002A_0352);
        @(negedge clk);
        check("R6 irq one cycle", {31'h0, host_irq}, 0);
        complete(0, 8'h11, 8'h77);
        check("R7 no irq when idle", {31'h0, host_irq}, 0);
        hread(8'h04, 0, d); check("R7 status kept", d, 32'h002A_0352);
    endtask

    task automatic t_rbuf();
        logic [31:0] d;
        logic [31:0] w [4] = '{32'h4433_2211, 32'h8877_6655, 32'hCCBB_AA99, 32'h00FF_EEDD};
        for (int k = 0; k < 4; k++) begin
            hread(8'h90 + 8'(4*k), 0, d); check("R9 inbound word", d, w[k]);
        end
        for (int n = 0; n < 16; n++) begin
            hread(8'h90 + 8'(n), 1, d);
            check("R10 inbound byte", d, {24'h0, w[n/4][(n%4)*8 +: 8]});
        end
        hwrite(8'h90, 32'h1234_5678);
        hread(8'h90, 0, d); check("R11 inbound not host-writable", d, w[0]);
    endtask

    task automatic t_cmd_poll();
        logic [31:0] d;
        hwrite(8'h00, 32'h0004_3011);
        check("R2 doorbell again", {31'h0, ctl_doorbell}, 1);
        hread(8'h04, 0, d); check("R2 error cleared on accept", d, 32'h0000_0331);
        hwrite(8'h04, 32'hFFFF_FFFF);
        hread(8'h04, 0, d); check("R11 status not writable", d, 32'h0000_0331);
        complete(0, 8'h00, 8'h05);
        check("R6 no irq without request", {31'h0, host_irq}, 0);
        @(negedge clk);
        check("R6 still no irq", {31'h0, host_irq}, 0);
        hread(8'h04, 0, d); check("R3 clean completion", d, 32'h0000_0530);
        hread(8'h40, 0, d); check("R11 unmapped reads 0", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_wbuf();
        t_cmd_ioc();
        t_rbuf();
        t_cmd_poll();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule